// File: doc/BRIEF.md
# Fault Pin Conditioner

This block prepares an external fault pin for use by a PWM stage. The raw pin is brought into the clock domain through a two-flop synchroniser. An optional glitch filter can then be switched in. After that, a selectable edge detector turns the chosen transition into a one-cycle fault event, but only while protection is armed. Each event also sets a sticky fault flag, which stays set until a clear strobe is given. An interrupt request is driven from the flag when the interrupt enable is set.

All the control inputs are plain level signals that take effect on the next clock edge. There is no data stream and no handshake. The consumer takes `fault_evt` as a single-cycle strobe, reads `fault_flag` as a level, and pulses `flag_clr` to acknowledge the flag. The shutdown of PWM outputs and any other choice of fault source lie outside this block.

Top module: `fault_pin_cond`

## Requirements
- R1: With the filter off, a pin level change first sampled at clock edge n gives `fault_evt` high during the cycle after edge n+2 (three sampling edges of latency), provided the change is the selected edge.
- R2: When `edge_rise`=1, only a low-to-high transition of the conditioned pin gives an event. When `edge_rise`=0, only a high-to-low transition does.
- R3: While `prot_en`=0, no event is produced and the flag is not set, whatever the pin does.
- R4: With `nc_en`=1, the conditioned signal changes only after four consecutive synchronised samples of the new level. A pin pulse of three cycles or fewer produces no event.
- R5: With `nc_en`=1, an event arrives exactly four cycles later than it does with the filter off (seven edges after first sampling).
- R6: Each detected edge gives exactly one cycle of `fault_evt` high. Under a constant edge selection, two events are never adjacent.
- R7: An event sets `fault_flag` in the same cycle that `fault_evt` rises. The flag then stays high until a `flag_clr` strobe is sampled, and it becomes low on the edge that samples that strobe.
- R8: If an edge is captured on the same clock edge as `flag_clr`, the flag stays set.
- R9: `fault_irq` is high exactly when `fault_flag` and `irq_en` are both high. It responds combinationally to `irq_en`.
- R10: During and after an active-low reset, `fault_evt`, `fault_flag` and `fault_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | 1 | Asynchronous fault pin |
| prot_en | input | 1 | Arms fault protection (1 = events allowed) |
| nc_en | input | 1 | Switches in the four-sample glitch filter |
| edge_rise | input | 1 | Edge select: 1 = rising, 0 = falling |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | One-cycle strobe that clears the fault flag |
| fault_evt | output | 1 | One-cycle fault event |
| fault_flag | output | 1 | Sticky fault flag |
| fault_irq | output | 1 | Interrupt request |

## Verification
The bound checker examines every cycle for the rules that need no knowledge of pin history. Events occur only while protection was armed, events never run back to back, the flag rises only with an event and holds until a clear, a clear loses only to a coincident event, and the interrupt stays inside the flag and its enable. The latency figures, the edge polarity and the rejection of short pulses all depend on the pin's waveform over several cycles. The directed scenarios alone show these: they count edges from each pin change to the event and confirm that no event follows a short pulse.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_pol_e;

  localparam int unsigned SYNC_STAGES_DEF = 2;
  localparam int unsigned FILT_LEN_DEF    = 4;

  // True when cur/prev form the selected transition
  function automatic logic edge_hit(edge_pol_e pol, logic cur, logic prev);
    return (pol == EDGE_RISE) ? (cur & ~prev) : (~cur & prev);
  endfunction

endpackage

// File: rtl/fpc_sync.sv
module fpc_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RST_VAL;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fpc_filter.sv
module fpc_filter #(
  parameter int unsigned LEN     = 4,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int unsigned HIST = LEN - 1;

  logic [HIST-1:0] hist;
  logic [LEN-1:0]  win;
  logic            q_r;

  // Current sample plus the HIST previous ones
  assign win = {hist, d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= {HIST{RST_VAL}};
      q_r  <= RST_VAL;
    end else begin
      hist <= win[HIST-1:0];
      if (&win)       q_r <= 1'b1;
      else if (~|win) q_r <= 1'b0;
    end
  end

  assign q = q_r;
endmodule

// File: rtl/fpc_edge.sv
module fpc_edge
  import fpc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sig,
  input  edge_pol_e pol,
  input  logic      arm,
  output logic      hit
);
  logic prev;

  // prev follows sig even when disarmed, so arming never sees a stale edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= sig;
  end

  assign hit = arm & edge_hit(pol, sig, prev);
endmodule

// File: rtl/fpc_flag.sv
module fpc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clr,
  input  logic ie,
  output logic evt,
  output logic flag,
  output logic irq
);
  logic evt_q;
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      evt_q <= hit;
      if (hit)      flag_q <= 1'b1;   // new event beats clear
      else if (clr) flag_q <= 1'b0;
    end
  end

  assign evt  = evt_q;
  assign flag = flag_q;
  assign irq  = flag_q & ie;
endmodule

// File: rtl/fault_pin_cond.sv
module fault_pin_cond
  import fpc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF,
  parameter int unsigned FILT_LEN    = FILT_LEN_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_raw,
  input  logic prot_en,
  input  logic nc_en,
  input  logic edge_rise,
  input  logic irq_en,
  input  logic flag_clr,
  output logic fault_evt,
  output logic fault_flag,
  output logic fault_irq
);
  logic pin_s;
  logic pin_f;
  logic cond;
  logic hit;

  fpc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_raw), .q(pin_s)
  );

  generate
    if (FILT_LEN > 1) begin : g_filt
      fpc_filter #(.LEN(FILT_LEN), .RST_VAL(1'b0)) u_filt (
        .clk(clk), .rst_n(rst_n), .d(pin_s), .q(pin_f)
      );
    end else begin : g_nofilt
      assign pin_f = pin_s;
    end
  endgenerate

  assign cond = nc_en ? pin_f : pin_s;

  fpc_edge u_edge (
    .clk(clk), .rst_n(rst_n), .sig(cond),
    .pol(edge_pol_e'(edge_rise)), .arm(prot_en), .hit(hit)
  );

  fpc_flag u_flag (
    .clk(clk), .rst_n(rst_n), .hit(hit), .clr(flag_clr), .ie(irq_en),
    .evt(fault_evt), .flag(fault_flag), .irq(fault_irq)
  );
endmodule

// File: rtl/fault_pin_cond_chk.sv
module fault_pin_cond_chk (
  input logic clk,
  input logic rst_n,
  input logic prot_en,
  input logic edge_rise,
  input logic irq_en,
  input logic flag_clr,
  input logic fault_evt,
  input logic fault_flag,
  input logic fault_irq
);
  p_evt_needs_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |-> $past(prot_en));

  p_evt_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt && (edge_rise == $past(edge_rise)) |=> !fault_evt);

  p_evt_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |-> fault_flag);

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_flag && !flag_clr |=> fault_flag);

  p_flag_rise_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_flag) |-> fault_evt);

  p_clr_vs_evt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> (!fault_flag || fault_evt));

  p_irq_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !fault_irq);

  p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_irq |-> fault_flag);

  p_quiet_after_reset_r10: assert property (@(posedge clk)
    !rst_n |=> (!fault_evt && !fault_flag));
endmodule

bind fault_pin_cond fault_pin_cond_chk u_chk (
  .clk(clk), .rst_n(rst_n), .prot_en(prot_en), .edge_rise(edge_rise),
  .irq_en(irq_en), .flag_clr(flag_clr), .fault_evt(fault_evt),
  .fault_flag(fault_flag), .fault_irq(fault_irq)
);

// File: tb/tb_fault_pin_cond.sv
module tb_fault_pin_cond;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WDOG_CYC   = 100000;

  logic clk = 1'b0;
  logic rst_n;
  logic pin_raw, prot_en, nc_en, edge_rise, irq_en, flag_clr;
  logic fault_evt, fault_flag, fault_irq;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  fault_pin_cond dut (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .prot_en(prot_en),
    .nc_en(nc_en), .edge_rise(edge_rise), .irq_en(irq_en),
    .flag_clr(flag_clr), .fault_evt(fault_evt), .fault_flag(fault_flag),
    .fault_irq(fault_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WDOG_CYC && !done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Count negedges from now until fault_evt is seen (0 = never within lim)
  task automatic wait_evt(int lim, output int n);
    n = 0;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (fault_evt && n == 0) n = i;
      if (n != 0) break;
    end
  endtask

  task automatic count_evts(int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (fault_evt) n++;
    end
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 evt in reset", fault_evt, 0);
    chk("R10 flag in reset", fault_flag, 0);
    chk("R10 irq in reset", fault_irq, 0);
    rst_n = 1'b1;
    idle(3);
    chk("R10 evt after reset", fault_evt, 0);
    chk("R10 flag after reset", fault_flag, 0);
  endtask

  task automatic t_rise_latency();
    int n;
    prot_en = 1'b1; edge_rise = 1'b1; nc_en = 1'b0;
    pin_raw = 1'b1;
    wait_evt(20, n);
    chk("R1 rise latency", n, 3);
    chk("R7 flag with evt", fault_flag, 1);
    @(negedge clk);
    chk("R6 evt one cycle", fault_evt, 0);
    clear_flag();
    chk("R7 flag cleared", fault_flag, 0);
    pin_raw = 1'b0;
    count_evts(10, n);
    chk("R2 falling ignored in rise mode", n, 0);
    chk("R2 flag untouched by falling", fault_flag, 0);
  endtask

  task automatic t_fall_mode();
    int n;
    edge_rise = 1'b0;
    idle(2);
    pin_raw = 1'b1;
    count_evts(10, n);
    chk("R2 rising ignored in fall mode", n, 0);
    pin_raw = 1'b0;
    wait_evt(20, n);
    chk("R2 fall latency", n, 3);
    idle(2);
    clear_flag();
    edge_rise = 1'b1;
    idle(2);
  endtask

  task automatic t_disarmed();
    int n;
    prot_en = 1'b0;
    pin_raw = 1'b1; idle(4);
    pin_raw = 1'b0; idle(4);
    pin_raw = 1'b1;
    count_evts(8, n);
    chk("R3 no event when disarmed", n, 0);
    chk("R3 no flag when disarmed", fault_flag, 0);
    pin_raw = 1'b0;
    idle(6);
    prot_en = 1'b1;
    idle(2);
  endtask

  task automatic t_filter_latency();
    int n;
    nc_en = 1'b1;
    idle(2);
    pin_raw = 1'b1;
    wait_evt(20, n);
    chk("R5 filtered latency", n, 7);
    clear_flag();
    pin_raw = 1'b0;
    idle(12);
  endtask

  task automatic t_glitch();
    int n;
    pin_raw = 1'b1; idle(3); pin_raw = 1'b0;
    count_evts(15, n);
    chk("R4 3-cycle pulse rejected", n, 0);
    chk("R4 flag after rejected pulse", fault_flag, 0);
    pin_raw = 1'b1; idle(4); pin_raw = 1'b0;
    count_evts(15, n);
    chk("R4 4-cycle pulse passes", n, 1);
    clear_flag();
    nc_en = 1'b0;
    idle(4);
  endtask

  task automatic t_sticky_irq();
    int n;
    irq_en = 1'b1;
    #1;
    chk("R9 irq low without flag", fault_irq, 0);
    pin_raw = 1'b1;
    wait_evt(20, n);
    idle(10);
    chk("R7 flag held", fault_flag, 1);
    chk("R9 irq flag&en", fault_irq, 1);
    irq_en = 1'b0;
    #1;
    chk("R9 irq masked", fault_irq, 0);
    irq_en = 1'b1;
    #1;
    chk("R9 irq unmasked", fault_irq, 1);
    clear_flag();
    chk("R7 flag clear by strobe", fault_flag, 0);
    chk("R9 irq drops with flag", fault_irq, 0);
    irq_en = 1'b0;
    pin_raw = 1'b0;
    idle(6);
  endtask

  task automatic t_coincident();
    pin_raw = 1'b1;
    idle(2);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk("R8 evt with clear", fault_evt, 1);
    chk("R8 event beats clear", fault_flag, 1);
    clear_flag();
    chk("R8 later clear works", fault_flag, 0);
  endtask

  initial begin
    rst_n = 1'b0; pin_raw = 1'b0; prot_en = 1'b0; nc_en = 1'b0;
    edge_rise = 1'b1; irq_en = 1'b0; flag_clr = 1'b0;
    idle(3);
    t_reset();
    t_rise_latency();
    t_fall_mode();
    t_disarmed();
    t_filter_latency();
    t_glitch();
    t_sticky_irq();
    t_coincident();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule